// File: doc/BRIEF.md
# Full-duplex UART with one- or two-byte frames

This block is a full-duplex asynchronous serial transceiver. Each frame carries either one data byte or two, and transmit and receive choose their length and parity on their own. A frame is a low start bit, then the data bits least significant first with the low byte ahead of the high byte, then an optional parity bit, then one high stop bit. Bit timing comes from a clock-enable input, `baud_tick`, that pulses at sixteen times the bit rate. Every bit therefore lasts sixteen ticks.

To send, software places the low and high bytes on the transmit byte inputs and pulses `tx_go`. The block then shifts the frame out on `txd`. When the stop bit ends, it raises a sticky transmit-end flag.

The receiver samples each bit at its midpoint. It refuses a start bit that has gone high again by the middle of that bit. At the end of a frame it presents the low and high received bytes together with an error indication, and it raises a sticky receive-end flag. Software clears each flag with a clear pulse. The enable inputs put the receive side and the transmit side into serial mode separately.

Top module: `uart_dual_len`

## Requirements
- R1: With the transmitter disabled, or with no frame in progress, `txd` stays high and `tx_busy` is low. After reset, both end flags read 0 and both received bytes read 0x00.
- R2: An accepted transmit request drives `txd` through the following bits, each lasting 16 ticks of `baud_tick`: a low start bit, the data bits least significant first, the parity bit when enabled, and a high stop bit. The request is accepted at the clock edge where `tx_go` is seen.
- R3: `tx_wide`=0 sends the 8 bits of `tx_byte_lo`. `tx_wide`=1 sends 16 bits: `tx_byte_lo` first, then `tx_byte_hi`.
- R4: With `tx_par_on`=1, a parity bit follows the data. `tx_par_odd`=0 selects even parity, so the parity bit plus the data hold an even number of ones. `tx_par_odd`=1 selects odd parity.
- R5: A `tx_go` pulse has no effect while a frame is in progress or while `tx_enable` is 0.
- R6: `tx_end_flag` goes to 1 on the clock edge that ends the stop bit. It stays at 1 until a `tx_end_clr` pulse, and a set on the same edge wins over the clear.
- R7: The receiver takes frames in the same format, with its length and parity chosen by `rx_wide`, `rx_par_on` and `rx_par_odd`. A two-byte frame puts the first byte in `rx_byte_lo` and the second in `rx_byte_hi`. A one-byte frame puts its byte in `rx_byte_lo` and sets `rx_byte_hi` to 0x00.
- R8: A low pulse on `rxd` that has returned high by the middle of the start bit produces no frame and sets no flag.
- R9: A parity mismatch or a low stop bit sets `rx_bad` to 1 for that frame. The frame still completes: the bytes update and `rx_end_flag` is set.
- R10: With `rx_enable`=0, frames on `rxd` are ignored. The received bytes and `rx_end_flag` are left unchanged.
- R11: `rx_end_flag` stays at 1 after a frame until a `rx_end_clr` pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Clock enable at 16x the bit rate |
| tx_enable | input | 1 | Transmit side in serial mode |
| tx_wide | input | 1 | Transmit length: 0 one byte, 1 two bytes |
| tx_par_on | input | 1 | Transmit parity bit present |
| tx_par_odd | input | 1 | Transmit parity: 0 even, 1 odd |
| tx_byte_lo | input | 8 | Transmit low byte (sent first) |
| tx_byte_hi | input | 8 | Transmit high byte |
| tx_go | input | 1 | Start-of-transmit request pulse |
| txd | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | Frame in progress |
| tx_end_flag | output | 1 | Sticky transmit-end flag |
| tx_end_clr | input | 1 | Clears the transmit-end flag |
| rx_enable | input | 1 | Receive side in serial mode |
| rx_wide | input | 1 | Receive length: 0 one byte, 1 two bytes |
| rx_par_on | input | 1 | Receive parity bit expected |
| rx_par_odd | input | 1 | Receive parity: 0 even, 1 odd |
| rxd | input | 1 | Serial input |
| rx_byte_lo | output | 8 | Received low byte |
| rx_byte_hi | output | 8 | Received high byte, 0x00 in one-byte mode |
| rx_bad | output | 1 | Parity or stop error on the last frame |
| rx_end_flag | output | 1 | Sticky receive-end flag |
| rx_end_clr | input | 1 | Clears the receive-end flag |

## Verification
The transmitter is compared on every clock against a bit-queue model. Any miscount of the sixteen-tick bit length, any reversal of bit or byte order, or any wrong parity sense therefore shows up as a `txd` mismatch on the exact clock where it occurs. The bench fires a second request in the middle of a frame and one while the transmitter is disabled. A design that accepted either would change the waveform and the received byte.

On the receive side, the bench aims at four cases:
- A start glitch shorter than half a bit. A design that accepted it would set the end flag.
- A parity mismatch and a low stop bit. A design that dropped these frames would leave the data and the flag stale.
- A one-byte frame arriving after a two-byte frame. A design that kept the old high byte would fail the 0x00 check.
- Frames arriving while the receiver is disabled.

// File: rtl/uartdl_pkg.sv
package uartdl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } phase_t;

  // Parity bit over the low nb bits of d: even sense gives XOR, odd sense its inverse.
  function automatic logic frame_parity(input logic [31:0] d, input int nb, input logic odd);
    logic x;
    x = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (i < nb) x = x ^ d[i];
    end
    return x ^ odd;
  endfunction

endpackage

// File: rtl/uartdl_tx.sv
module uartdl_tx
  import uartdl_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              go,
  input  logic              wide,
  input  logic              par_on,
  input  logic              par_odd,
  input  logic [BYTE_W-1:0] lo,
  input  logic [BYTE_W-1:0] hi,
  output logic              txd,
  output logic              busy,
  output logic              done
);
  localparam int FW = 2 * BYTE_W;
  localparam int CW = $clog2(OVS);
  localparam int NW = $clog2(FW + 1);

  phase_t         ph;
  logic [CW-1:0]  cnt;
  logic [NW-1:0]  bitn;
  logic [FW-1:0]  sr;
  logic           wide_q, pon_q, pbit_q, txd_q;
  logic           accept, bit_end;
  logic [NW-1:0]  nbits;

  assign accept  = en && go && (ph == PH_IDLE);
  assign bit_end = tick && (cnt == CW'(OVS - 1));
  assign nbits   = wide_q ? NW'(FW) : NW'(BYTE_W);
  assign done    = en && bit_end && (ph == PH_STOP);
  assign busy    = (ph != PH_IDLE);
  assign txd     = txd_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      sr     <= '0;
      wide_q <= 1'b0;
      pon_q  <= 1'b0;
      pbit_q <= 1'b0;
      txd_q  <= 1'b1;
    end else if (accept) begin
      ph     <= PH_START;
      cnt    <= '0;
      txd_q  <= 1'b0;
      sr     <= {hi, lo};
      wide_q <= wide;
      pon_q  <= par_on;
      pbit_q <= frame_parity(32'({hi, lo}), wide ? FW : BYTE_W, par_odd);
    end else if (busy && tick) begin
      if (bit_end) begin
        cnt <= '0;
        case (ph)
          PH_START: begin
            ph    <= PH_DATA;
            txd_q <= sr[0];
            sr    <= sr >> 1;
            bitn  <= NW'(1);
          end
          PH_DATA: begin
            if (bitn == nbits) begin
              ph    <= pon_q ? PH_PAR : PH_STOP;
              txd_q <= pon_q ? pbit_q : 1'b1;
            end else begin
              txd_q <= sr[0];
              sr    <= sr >> 1;
              bitn  <= bitn + 1'b1;
            end
          end
          PH_PAR: begin
            ph    <= PH_STOP;
            txd_q <= 1'b1;
          end
          default: begin
            ph    <= PH_IDLE;
            txd_q <= 1'b1;
          end
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R2
  tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
  // R2
  tx_stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_STOP) |-> txd);
  // R5
  tx_go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go && en && !done) |=> busy);

endmodule

// File: rtl/uartdl_rx.sv
module uartdl_rx
  import uartdl_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              wide,
  input  logic              par_on,
  input  logic              par_odd,
  input  logic              rxd,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              bad,
  output logic              done,
  output logic              busy
);
  localparam int FW   = 2 * BYTE_W;
  localparam int CW   = $clog2(OVS);
  localparam int NW   = $clog2(FW + 1);
  localparam int HALF = OVS / 2;

  logic           s1, s2;
  phase_t         ph;
  logic [CW-1:0]  cnt;
  logic [NW-1:0]  bitn;
  logic [FW-1:0]  sr;
  logic           wide_q, odd_q, pon_q, pbit;
  logic [FW-1:0]  word;
  logic [NW-1:0]  nbits;
  logic           bit_end, start_reject, par_err;

  assign bit_end      = tick && (cnt == CW'(OVS - 1));
  assign start_reject = tick && (ph == PH_START) && (cnt == CW'(HALF - 1)) && s2;
  assign nbits        = wide_q ? NW'(FW) : NW'(BYTE_W);
  assign word         = wide_q ? sr : {{BYTE_W{1'b0}}, sr[FW-1:BYTE_W]};
  assign par_err      = pon_q && (pbit != frame_parity(32'(word), int'(nbits), odd_q));
  assign done         = en && bit_end && (ph == PH_STOP);
  assign busy         = (ph != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE; cnt <= '0; bitn <= '0; sr <= '0;
      wide_q <= 1'b0; odd_q <= 1'b0; pon_q <= 1'b0; pbit <= 1'b0;
      lo <= '0; hi <= '0; bad <= 1'b0;
    end else if (!en) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else if (tick) begin
      case (ph)
        PH_IDLE: begin
          if (!s2) begin
            ph     <= PH_START;
            cnt    <= '0;
            wide_q <= wide;
            odd_q  <= par_odd;
            pon_q  <= par_on;
          end
        end
        PH_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            bitn <= '0;
            ph   <= s2 ? PH_IDLE : PH_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DATA: begin
          if (bit_end) begin
            cnt  <= '0;
            sr   <= {s2, sr[FW-1:1]};
            bitn <= bitn + 1'b1;
            if (NW'(bitn + 1'b1) == nbits) ph <= pon_q ? PH_PAR : PH_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_PAR: begin
          if (bit_end) begin
            cnt  <= '0;
            pbit <= s2;
            ph   <= PH_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (bit_end) begin
            cnt <= '0;
            ph  <= PH_IDLE;
            lo  <= word[BYTE_W-1:0];
            hi  <= word[FW-1:BYTE_W];
            bad <= par_err || !s2;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R8
  rx_false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start_reject) |=> !busy);
  // R7
  rx_one_byte_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wide_q) |=> (hi == '0));
  // R9
  rx_frame_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/uart_dual_len.sv
module uart_dual_len #(
  parameter int BYTE_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_enable,
  input  logic              tx_wide,
  input  logic              tx_par_on,
  input  logic              tx_par_odd,
  input  logic [BYTE_W-1:0] tx_byte_lo,
  input  logic [BYTE_W-1:0] tx_byte_hi,
  input  logic              tx_go,
  output logic              txd,
  output logic              tx_busy,
  output logic              tx_end_flag,
  input  logic              tx_end_clr,
  input  logic              rx_enable,
  input  logic              rx_wide,
  input  logic              rx_par_on,
  input  logic              rx_par_odd,
  input  logic              rxd,
  output logic [BYTE_W-1:0] rx_byte_lo,
  output logic [BYTE_W-1:0] rx_byte_hi,
  output logic              rx_bad,
  output logic              rx_end_flag,
  input  logic              rx_end_clr
);
  logic tx_done_ev, rx_done_ev, rx_active;

  uartdl_tx #(.BYTE_W(BYTE_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(tx_enable), .go(tx_go),
    .wide(tx_wide), .par_on(tx_par_on), .par_odd(tx_par_odd),
    .lo(tx_byte_lo), .hi(tx_byte_hi),
    .txd(txd), .busy(tx_busy), .done(tx_done_ev)
  );

  uartdl_rx #(.BYTE_W(BYTE_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(rx_enable),
    .wide(rx_wide), .par_on(rx_par_on), .par_odd(rx_par_odd), .rxd(rxd),
    .lo(rx_byte_lo), .hi(rx_byte_hi), .bad(rx_bad),
    .done(rx_done_ev), .busy(rx_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_end_flag <= 1'b0;
      rx_end_flag <= 1'b0;
    end else begin
      if (tx_done_ev)      tx_end_flag <= 1'b1;
      else if (tx_end_clr) tx_end_flag <= 1'b0;
      if (rx_done_ev)      rx_end_flag <= 1'b1;
      else if (rx_end_clr) rx_end_flag <= 1'b0;
    end
  end

  // R6
  tx_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_ev |=> tx_end_flag);
  // R11
  rx_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end_flag && !rx_end_clr) |=> rx_end_flag);
  // R10
  rx_disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> !rx_active);

endmodule

// File: tb/uart_dual_len_test.sv
`timescale 1ns/1ps
module uart_dual_len_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] tdiv = 2'd0;
  always @(negedge clk) tdiv <= tdiv + 2'd1;
  wire baud_tick = (tdiv == 2'd3);

  logic tx_enable = 1'b1, tx_wide = 1'b0, tx_par_on = 1'b0, tx_par_odd = 1'b0;
  logic [7:0] tx_byte_lo = 8'h00, tx_byte_hi = 8'h00;
  logic tx_go = 1'b0, tx_end_clr = 1'b0;
  logic rx_enable = 1'b1, rx_wide = 1'b0, rx_par_on = 1'b0, rx_par_odd = 1'b0;
  logic rx_end_clr = 1'b0, loop = 1'b1, rx_drv = 1'b1;
  wire  txd, tx_busy, tx_end_flag, rx_bad, rx_end_flag;
  wire [7:0] rx_byte_lo, rx_byte_hi;
  wire  rxd = loop ? txd : rx_drv;

  uart_dual_len uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_enable(tx_enable),
    .tx_wide(tx_wide), .tx_par_on(tx_par_on), .tx_par_odd(tx_par_odd),
    .tx_byte_lo(tx_byte_lo), .tx_byte_hi(tx_byte_hi), .tx_go(tx_go),
    .txd(txd), .tx_busy(tx_busy), .tx_end_flag(tx_end_flag), .tx_end_clr(tx_end_clr),
    .rx_enable(rx_enable), .rx_wide(rx_wide), .rx_par_on(rx_par_on),
    .rx_par_odd(rx_par_odd), .rxd(rxd), .rx_byte_lo(rx_byte_lo),
    .rx_byte_hi(rx_byte_hi), .rx_bad(rx_bad), .rx_end_flag(rx_end_flag),
    .rx_end_clr(rx_end_clr)
  );

  int compared = 0;
  int mismatched = 0;
  bit summary_done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    end
  endtask

  // Behavioural transmit model: a queue of line levels, each held 16 ticks.
  logic m_q[$];
  int   m_ticks = 0;
  bit   m_busy = 1'b0;
  bit   m_flag = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_busy = 1'b0; m_flag = 1'b0; m_ticks = 0;
    end else begin
      if (tx_end_clr) m_flag = 1'b0;
      if (!tx_enable) begin
        m_q.delete(); m_busy = 1'b0;
      end else if (m_busy) begin
        if (baud_tick) begin
          m_ticks++;
          if (m_ticks == 16) begin
            m_ticks = 0;
            void'(m_q.pop_front());
            if (m_q.size() == 0) begin m_busy = 1'b0; m_flag = 1'b1; end
          end
        end
      end else if (tx_go) begin
        int n, ones;
        logic [15:0] d;
        d = {tx_byte_hi, tx_byte_lo};
        n = tx_wide ? 16 : 8;
        ones = 0;
        m_q.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
          m_q.push_back(d[i]);
          if (d[i]) ones++;
        end
        if (tx_par_on) m_q.push_back(tx_par_odd ? (ones % 2 == 0) : (ones % 2 == 1));
        m_q.push_back(1'b1);
        m_busy = 1'b1;
        m_ticks = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !summary_done) begin
      logic e;
      e = m_busy ? m_q[0] : 1'b1;
      // R1 R2 R3 R4 R5: line level every clock
      chk(txd === e, "R2 txd level", txd, e);
      chk(tx_busy === m_busy, "R5 tx_busy", tx_busy, m_busy);
      // R6
      chk(tx_end_flag === m_flag, "R6 tx_end_flag", tx_end_flag, m_flag);
    end
  end

  task automatic clear_flags();
    @(negedge clk); tx_end_clr = 1'b1; rx_end_clr = 1'b1;
    @(negedge clk); tx_end_clr = 1'b0; rx_end_clr = 1'b0;
  endtask

  task automatic pulse_go();
    @(negedge clk); tx_go = 1'b1;
    @(negedge clk); tx_go = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (tx_busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] lo, input logic [7:0] hi, input bit wide,
                      input bit pon, input bit todd, input bit rodd);
    @(negedge clk);
    tx_byte_lo = lo; tx_byte_hi = hi; tx_wide = wide; tx_par_on = pon; tx_par_odd = todd;
    rx_wide = wide; rx_par_on = pon; rx_par_odd = rodd;
    pulse_go();
    wait_idle();
  endtask

  task automatic drive_bits(input logic [19:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      rx_drv = b[i];
      repeat (64) @(negedge clk);
    end
    rx_drv = 1'b1;
  endtask

  task automatic rx_expect(input string req, input logic [7:0] lo, input logic [7:0] hi,
                           input bit bad);
    chk(rx_end_flag === 1'b1, {req, " rx_end_flag"}, rx_end_flag, 1);
    chk(rx_byte_lo === lo, {req, " rx_byte_lo"}, rx_byte_lo, lo);
    chk(rx_byte_hi === hi, {req, " rx_byte_hi"}, rx_byte_hi, hi);
    chk(rx_bad === bad, {req, " rx_bad"}, rx_bad, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(txd === 1'b1, "R1 txd after reset", txd, 1);
    chk(tx_end_flag === 1'b0 && rx_end_flag === 1'b0, "R1 flags after reset",
        {tx_end_flag, rx_end_flag}, 0);
    chk(rx_byte_lo === 8'h00 && rx_byte_hi === 8'h00, "R1 rx bytes after reset",
        {rx_byte_hi, rx_byte_lo}, 0);

    // R3 R7: one-byte frame, no parity
    send(8'hA5, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0);
    rx_expect("R7 one-byte", 8'hA5, 8'h00, 1'b0);
    clear_flags();

    // R3 R4 R7: two-byte frame, even parity
    send(8'h81, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b0);
    rx_expect("R3 two-byte even", 8'h81, 8'h3C, 1'b0);
    clear_flags();

    // R4: two-byte frame, odd parity
    send(8'hFE, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1);
    rx_expect("R4 two-byte odd", 8'hFE, 8'hFF, 1'b0);
    clear_flags();

    // R7: one-byte after two-byte, high byte must read 0x00
    send(8'h00, 8'h55, 1'b0, 1'b1, 1'b1, 1'b1);
    rx_expect("R7 one-byte hi zero", 8'h00, 8'h00, 1'b0);
    clear_flags();

    // R5: request during a frame is ignored
    @(negedge clk);
    tx_byte_lo = 8'h3A; tx_wide = 1'b0; tx_par_on = 1'b0;
    rx_wide = 1'b0; rx_par_on = 1'b0;
    pulse_go();
    repeat (200) @(negedge clk);
    tx_byte_lo = 8'hC4;
    pulse_go();
    wait_idle();
    rx_expect("R5 busy request ignored", 8'h3A, 8'h00, 1'b0);
    repeat (300) @(negedge clk);
    chk(rx_byte_lo === 8'h3A, "R5 no second frame", rx_byte_lo, 8'h3A);
    clear_flags();

    // R5: request while transmitter disabled is ignored
    @(negedge clk); tx_enable = 1'b0;
    pulse_go();
    repeat (200) @(negedge clk);
    chk(tx_busy === 1'b0 && txd === 1'b1, "R5 disabled request", {tx_busy, txd}, 1);
    chk(rx_end_flag === 1'b0, "R5 nothing received", rx_end_flag, 0);
    tx_enable = 1'b1;

    // R9: parity mismatch still completes
    send(8'h5B, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
    rx_expect("R9 parity mismatch", 8'h5B, 8'h00, 1'b1);
    clear_flags();

    // R9: low stop bit, driven directly (start, 0x5A LSB first, stop low)
    @(negedge clk); loop = 1'b0; rx_wide = 1'b0; rx_par_on = 1'b0;
    drive_bits({10'h3FF, 1'b0, 8'h5A, 1'b0}, 10);
    repeat (200) @(negedge clk);
    rx_expect("R9 low stop", 8'h5A, 8'h00, 1'b1);
    clear_flags();

    // R8: short glitch rejected
    @(negedge clk); rx_drv = 1'b0;
    repeat (12) @(negedge clk); rx_drv = 1'b1;
    repeat (300) @(negedge clk);
    chk(rx_end_flag === 1'b0, "R8 glitch no frame", rx_end_flag, 0);
    chk(rx_byte_lo === 8'h5A, "R8 glitch no data", rx_byte_lo, 8'h5A);

    // R10: receiver disabled ignores a frame
    @(negedge clk); loop = 1'b1; rx_enable = 1'b0;
    send(8'h99, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(rx_end_flag === 1'b0, "R10 disabled flag", rx_end_flag, 0);
    chk(rx_byte_lo === 8'h5A, "R10 disabled data", rx_byte_lo, 8'h5A);
    rx_enable = 1'b1;

    // R11: flag sticky until cleared
    send(8'h12, 8'h34, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (100) @(negedge clk);
    rx_expect("R11 sticky", 8'h12, 8'h34, 1'b0);
    clear_flags();
    @(negedge clk);
    chk(rx_end_flag === 1'b0, "R11 cleared", rx_end_flag, 0);
    chk(tx_end_flag === 1'b0, "R6 cleared", tx_end_flag, 0);

    repeat (10) @(negedge clk);
    summary();
    $finish;
  end
endmodule